// File: doc/BRIEF.md
# Scripted Address-Event Player

This block plays back a stream of address events that a host has scripted in advance. It drains 18-bit command words from a first-word-fall-through FIFO read port. Each word carries a two-bit opcode and a 16-bit operand. A word can emit one spike, pause for a number of AER clock ticks, or hold playback until an external 32-bit time counter reaches a target. A zero opcode ends the script. Spikes leave through a four-phase request/acknowledge handshake. They enter one of several arbiter input channels, which a select input picks. The block takes that channel away from the external sender that normally drives it.

The controller is a state machine with eight states. IDLE goes to FETCH when enabled. In FETCH the block pops a word when the FIFO is not empty and decodes it: END goes to STOPPED, EMIT goes to EMIT_REQ, DELAY goes to DELAY (or straight back to FETCH for a zero count), and TIME goes to TIME_LO. EMIT_REQ moves to EMIT_REL once acknowledge is high. EMIT_REL moves to FETCH once acknowledge is low. DELAY moves to FETCH when its tick counter reaches zero. TIME_LO pops the lower time half and moves to TIME_WAIT. TIME_WAIT moves to FETCH once the time input is at or past the target. Clearing the enable sends FETCH, DELAY, TIME_LO, TIME_WAIT and STOPPED to IDLE. The two handshake states always run to completion. Two one-cycle interrupt pulses report the FIFO going empty and its level dropping below half.

Top module: `seq_event_player`

## Requirements
- R1: After reset the block requests no event on the selected channel, pops nothing, and holds done low and both interrupt pulses low.
- R2: A word with bits 17:16 = 01 produces exactly one handshake on the selected channel with bits 15:0 as the label. Request stays high and the label stays stable until acknowledge is high, and request drops before the next word is read.
- R3: A word with bits 17:16 = 10 and a nonzero operand N delays the following word until exactly N cycles with the tick input high have passed. With no ticks, the following word is never read.
- R4: A delay word whose operand is 0 takes no ticks, and the next word runs without waiting for any tick.
- R5: A word with bits 17:16 = 11 carries the upper 16 bits of a time target, and the next word's bits 15:0 carry the lower 16 bits. Playback resumes only when the time input is greater than or equal to the target, so a target already in the past resumes at once.
- R6: A word is popped only when the FIFO is not empty and the block is enabled. With the enable low, the FIFO contents stay untouched.
- R7: The channel picked by the select input carries the block's request and label. That channel's external request is ignored and its external acknowledge is held low. Every other channel passes its external request, label and acknowledge straight through.
- R8: A word with bits 17:16 = 00 stops playback and sets done. Done stays set, and nothing more is popped, while the enable stays high. Clearing the enable clears done, and setting it again resumes with the next word.
- R9: Clearing the enable aborts a pending tick delay or time wait. A handshake already in flight still completes before the block goes idle.
- R10: While enabled, irq_empty pulses for one cycle after the FIFO empty flag rises, and irq_half pulses for one cycle after the below-half flag rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| seq_en | input | 1 | Playback enable |
| ch_sel | input | 2 | Arbiter channel that carries the generated events |
| fifo_empty | input | 1 | FIFO has no word |
| fifo_below_half | input | 1 | FIFO level is below half capacity |
| fifo_data | input | 18 | Head word of the FIFO (fall-through) |
| fifo_rd | output | 1 | Pop the head word at this clock edge |
| aer_tick | input | 1 | One-cycle AER clock tick enable |
| time_now | input | 32 | Free-running absolute time value |
| ext_req | input | 4 | Requests from external senders |
| ext_label | input | 64 | Labels from external senders, 16 bits per channel |
| ext_ack | output | 4 | Acknowledges returned to external senders |
| arb_req | output | 4 | Requests into the arbiter |
| arb_label | output | 64 | Labels into the arbiter, 16 bits per channel |
| arb_ack | input | 4 | Acknowledges from the arbiter |
| irq_empty | output | 1 | One-cycle pulse: FIFO became empty |
| irq_half | output | 1 | One-cycle pulse: FIFO dropped below half |
| seq_done | output | 1 | End-of-sequence reached |

## Verification
The assertions assume that the FIFO presents a valid head word whenever its empty flag is low, and that the word changes only after a pop. They also assume that the arbiter acknowledge follows the four-phase order, rising only while request is high and falling only after request drops, and that the channel select holds still while a handshake is open. The bench keeps to these assumptions. Its FIFO model updates data and flags only between clock edges, after a pop. Its receiver raises acknowledge only after seeing request and lowers it only after request falls. It changes the select only while no word is queued and no handshake is open.

// File: rtl/seq_pkg.sv
package seq_pkg;
    localparam int OP_W = 2;

    typedef enum logic [1:0] {
        OP_END   = 2'b00,
        OP_EMIT  = 2'b01,
        OP_DELAY = 2'b10,
        OP_TIME  = 2'b11
    } seq_op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_FETCH,
        S_EMIT_REQ,
        S_EMIT_REL,
        S_DELAY,
        S_TIME_LO,
        S_TIME_WAIT,
        S_STOPPED
    } seq_state_e;
endpackage

// File: rtl/seq_tick_timer.sv
module seq_tick_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    input  logic             clear,
    output logic             zero
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (tick && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);

    // R3
    tick_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load && !clear && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

    // R3
    no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load && !clear) |=> $stable(cnt_q));
endmodule

// File: rtl/seq_level_edge.sv
module seq_level_edge #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [N-1:0] level,
    output logic [N-1:0] pulse
);
    for (genvar i = 0; i < N; i++) begin : g_edge
        logic lvl_d;
        logic pls_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lvl_d <= 1'b1;
                pls_q <= 1'b0;
            end else begin
                lvl_d <= level[i];
                pls_q <= en & level[i] & ~lvl_d;
            end
        end

        assign pulse[i] = pls_q;

        // R10
        pulse_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
            pulse[i] |-> $past(level[i]));

        // R10
        pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
            pulse[i] |=> !pulse[i]);
    end
endmodule

// File: rtl/seq_chan_mux.sv
module seq_chan_mux #(
    parameter int NUM_CH  = 4,
    parameter int LABEL_W = 16,
    parameter int SEL_W   = 2
) (
    input  logic [SEL_W-1:0]          sel,
    input  logic                      seq_req,
    input  logic [LABEL_W-1:0]        seq_label,
    output logic                      seq_ack,
    input  logic [NUM_CH-1:0]         ext_req,
    input  logic [NUM_CH*LABEL_W-1:0] ext_label,
    output logic [NUM_CH-1:0]         ext_ack,
    output logic [NUM_CH-1:0]         arb_req,
    output logic [NUM_CH*LABEL_W-1:0] arb_label,
    input  logic [NUM_CH-1:0]         arb_ack
);
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic own;
        assign own = (sel == SEL_W'(c));
        assign arb_req[c] = own ? seq_req : ext_req[c];
        assign arb_label[c*LABEL_W +: LABEL_W] =
            own ? seq_label : ext_label[c*LABEL_W +: LABEL_W];
        assign ext_ack[c] = own ? 1'b0 : arb_ack[c];
    end

    assign seq_ack = arb_ack[sel];
endmodule

// File: rtl/seq_event_player.sv
module seq_event_player
    import seq_pkg::*;
#(
    parameter int LABEL_W = 16,
    parameter int NUM_CH  = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        seq_en,
    input  logic [$clog2(NUM_CH)-1:0]   ch_sel,
    input  logic                        fifo_empty,
    input  logic                        fifo_below_half,
    input  logic [LABEL_W+OP_W-1:0]     fifo_data,
    output logic                        fifo_rd,
    input  logic                        aer_tick,
    input  logic [2*LABEL_W-1:0]        time_now,
    input  logic [NUM_CH-1:0]           ext_req,
    input  logic [NUM_CH*LABEL_W-1:0]   ext_label,
    output logic [NUM_CH-1:0]           ext_ack,
    output logic [NUM_CH-1:0]           arb_req,
    output logic [NUM_CH*LABEL_W-1:0]   arb_label,
    input  logic [NUM_CH-1:0]           arb_ack,
    output logic                        irq_empty,
    output logic                        irq_half,
    output logic                        seq_done
);
    localparam int SEL_W  = $clog2(NUM_CH);
    localparam int TIME_W = 2 * LABEL_W;

    seq_state_e state_q, state_d;
    seq_op_e    op;
    logic [LABEL_W-1:0] operand;
    logic [LABEL_W-1:0] label_q;
    logic [LABEL_W-1:0] hi_q;
    logic [TIME_W-1:0]  target_q;
    logic               seq_req, seq_ack;
    logic               tmr_load, tmr_clear, tmr_zero;
    logic [1:0]         irq_vec;

    assign op      = seq_op_e'(fifo_data[LABEL_W +: OP_W]);
    assign operand = fifo_data[LABEL_W-1:0];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:      if (seq_en) state_d = S_FETCH;
            S_FETCH: begin
                if (!seq_en) begin
                    state_d = S_IDLE;
                end else if (!fifo_empty) begin
                    unique case (op)
                        OP_END:   state_d = S_STOPPED;
                        OP_EMIT:  state_d = S_EMIT_REQ;
                        OP_DELAY: state_d = (operand == '0) ? S_FETCH : S_DELAY;
                        OP_TIME:  state_d = S_TIME_LO;
                        default:  state_d = S_FETCH;
                    endcase
                end
            end
            S_EMIT_REQ:  if (seq_ack) state_d = S_EMIT_REL;
            S_EMIT_REL:  if (!seq_ack) state_d = S_FETCH;
            S_DELAY: begin
                if (!seq_en)       state_d = S_IDLE;
                else if (tmr_zero) state_d = S_FETCH;
            end
            S_TIME_LO: begin
                if (!seq_en)          state_d = S_IDLE;
                else if (!fifo_empty) state_d = S_TIME_WAIT;
            end
            S_TIME_WAIT: begin
                if (!seq_en)                    state_d = S_IDLE;
                else if (time_now >= target_q)  state_d = S_FETCH;
            end
            S_STOPPED:   if (!seq_en) state_d = S_IDLE;
            default:     state_d = S_IDLE;
        endcase
    end

    // outputs and strobes
    always_comb begin
        fifo_rd   = seq_en && !fifo_empty &&
                    (state_q == S_FETCH || state_q == S_TIME_LO);
        tmr_load  = (state_q == S_FETCH) && fifo_rd && (op == OP_DELAY);
        tmr_clear = (state_q == S_DELAY) && !seq_en;
        seq_req   = (state_q == S_EMIT_REQ);
        seq_done  = (state_q == S_STOPPED);
    end

    // operand capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            label_q  <= '0;
            hi_q     <= '0;
            target_q <= '0;
        end else begin
            if (state_q == S_FETCH && fifo_rd && op == OP_EMIT) label_q <= operand;
            if (state_q == S_FETCH && fifo_rd && op == OP_TIME) hi_q <= operand;
            if (state_q == S_TIME_LO && fifo_rd) target_q <= {hi_q, operand};
        end
    end

    seq_tick_timer #(.CNT_W(LABEL_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (operand),
        .tick     (aer_tick),
        .clear    (tmr_clear),
        .zero     (tmr_zero)
    );

    seq_chan_mux #(.NUM_CH(NUM_CH), .LABEL_W(LABEL_W), .SEL_W(SEL_W)) u_mux (
        .sel       (ch_sel),
        .seq_req   (seq_req),
        .seq_label (label_q),
        .seq_ack   (seq_ack),
        .ext_req   (ext_req),
        .ext_label (ext_label),
        .ext_ack   (ext_ack),
        .arb_req   (arb_req),
        .arb_label (arb_label),
        .arb_ack   (arb_ack)
    );

    seq_level_edge #(.N(2)) u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (seq_en),
        .level ({fifo_below_half, fifo_empty}),
        .pulse (irq_vec)
    );

    assign irq_empty = irq_vec[0];
    assign irq_half  = irq_vec[1];

    // R2
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_req && !seq_ack) |=> (seq_req && $stable(label_q)));

    // R6
    pop_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rd |-> (!fifo_empty && seq_en));

    // R8
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_done && seq_en) |=> (seq_done && !fifo_rd));

    // R5
    time_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_TIME_WAIT && seq_en && time_now < target_q) |=> (state_q == S_TIME_WAIT));

    // R9
    abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!seq_en && state_q != S_EMIT_REQ && state_q != S_EMIT_REL) |=> (state_q == S_IDLE));

    // R7
    own_ack_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_ack[ch_sel]);
endmodule

// File: tb/test_seq_event_player.sv
module test_seq_event_player;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic [1:0]  sel_v = 2'd0;
    logic        fifo_empty = 1'b1;
    logic        fifo_below_half = 1'b1;
    logic [17:0] fifo_data = '0;
    logic        fifo_rd;
    logic        tick = 1'b0;
    logic [31:0] time_v = '0;
    logic [3:0]  ext_req = '0;
    logic [63:0] ext_label = '0;
    logic [3:0]  ext_ack;
    logic [3:0]  arb_req;
    logic [63:0] arb_label;
    logic [3:0]  arb_ack;
    logic [3:0]  other_ack = '0;
    logic        mon_ack = 1'b0;
    int          mon_ch = 0;
    logic        irq_empty, irq_half, done;

    int checks = 0, errors = 0;
    int seen_cnt = 0, emit_cnt = 0, hold_err = 0, bad_pop = 0;
    int n_irq_e = 0, n_irq_h = 0;
    int ack_lat = 2;
    logic [17:0] fq[$];
    logic [15:0] exp_q[$];
    logic popflag = 1'b0;

    always #2.5 clk = ~clk;

    assign arb_ack = other_ack | (mon_ack ? (4'(1) << mon_ch) : 4'b0);

    seq_event_player i_seq_event_player (
        .clk(clk), .rst_n(rst_n), .seq_en(en), .ch_sel(sel_v),
        .fifo_empty(fifo_empty), .fifo_below_half(fifo_below_half),
        .fifo_data(fifo_data), .fifo_rd(fifo_rd), .aer_tick(tick),
        .time_now(time_v), .ext_req(ext_req), .ext_label(ext_label),
        .ext_ack(ext_ack), .arb_req(arb_req), .arb_label(arb_label),
        .arb_ack(arb_ack), .irq_empty(irq_empty), .irq_half(irq_half),
        .seq_done(done)
    );

    task automatic check_eq(input string req, input string what,
                            input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // FIFO model: fall-through head, pop seen at the edge
    always @(posedge clk) popflag <= fifo_rd;
    always @(negedge clk) begin
        if (popflag && fq.size() > 0) void'(fq.pop_front());
        if (rst_n && fifo_rd && fq.size() == 0) bad_pop++;
        fifo_empty      = (fq.size() == 0);
        fifo_data       = (fq.size() == 0) ? 18'h0 : fq[0];
        fifo_below_half = (fq.size() < 4);
        if (irq_empty) n_irq_e++;
        if (irq_half)  n_irq_h++;
    end

    task automatic push_word(input logic [17:0] w);
        @(negedge clk); #1;
        fq.push_back(w);
    endtask

    task automatic push_emit(input logic [15:0] lab);
        exp_q.push_back(lab);
        push_word({2'b01, lab});
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_emit(input int target, input int maxc);
        for (int i = 0; i < maxc && emit_cnt < target; i++) @(negedge clk);
    endtask

    task automatic pulse_tick();
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
    endtask

    // scoreboard monitor: acts as the arbiter receiver
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && arb_req[sel_v]) begin
                int ch;
                logic [15:0] lab;
                ch  = int'(sel_v);
                lab = arb_label[ch*16 +: 16];
                seen_cnt++;
                if (exp_q.size() == 0) check_eq("R2", "unexpected event", lab, 0);
                else check_eq("R2", "event label", lab, exp_q.pop_front());
                repeat (ack_lat) begin
                    @(negedge clk);
                    if (arb_label[ch*16 +: 16] !== lab || !arb_req[ch]) hold_err++;
                end
                mon_ch = ch; mon_ack = 1'b1;
                do @(negedge clk); while (arb_req[ch]);
                mon_ack = 1'b0;
                emit_cnt++;
            end
        end
    end

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int base, ie, ih;
        cycles(3);
        rst_n = 1'b1;
        cycles(1);
        // R1 reset state
        check_eq("R1", "arb_req", arb_req, 0);
        check_eq("R1", "fifo_rd", fifo_rd, 0);
        check_eq("R1", "done", done, 0);
        check_eq("R1", "irqs", {irq_empty, irq_half}, 0);

        en = 1'b1;
        // R2 plain emission
        push_emit(16'h26FE);
        push_emit(16'hF433);
        wait_emit(2, 60);
        check_eq("R2", "emit count", emit_cnt, 2);

        // R3 tick delay of 3
        push_emit(16'h1111);
        push_word({2'b10, 16'h0003});
        push_emit(16'h2222);
        wait_emit(3, 60);
        base = seen_cnt;
        cycles(20);
        check_eq("R3", "no ticks no event", seen_cnt, base);
        pulse_tick(); cycles(2); pulse_tick(); cycles(8);
        check_eq("R3", "two ticks no event", seen_cnt, base);
        pulse_tick(); cycles(10);
        check_eq("R3", "third tick releases", seen_cnt, base + 1);
        wait_emit(4, 40);

        // R4 zero delay
        push_word({2'b10, 16'h0000});
        push_emit(16'h3333);
        wait_emit(5, 14);
        check_eq("R4", "zero delay no wait", emit_cnt, 5);

        // R5 absolute time wait
        time_v = 32'h0000_FFFB;
        push_word({2'b11, 16'h0001});
        push_word({2'b00, 16'h0000});
        push_emit(16'h3344);
        base = seen_cnt;
        cycles(20);
        check_eq("R5", "time not reached", seen_cnt, base);
        time_v = 32'h0001_0000;
        wait_emit(6, 20);
        check_eq("R5", "time reached", emit_cnt, 6);
        push_word({2'b11, 16'h0000});
        push_word({2'b00, 16'h0005});
        push_emit(16'h75E2);
        wait_emit(7, 16);
        check_eq("R5", "past target immediate", emit_cnt, 7);

        // R7 channel routing
        cycles(4);
        sel_v = 2'd2;
        ext_req = 4'b0110;
        ext_label[16 +: 16] = 16'hAAAA;
        other_ack = 4'b0110;
        cycles(2);
        check_eq("R7", "passthrough req ch1", arb_req[1], 1);
        check_eq("R7", "passthrough label ch1", arb_label[16 +: 16], 16'hAAAA);
        check_eq("R7", "passthrough ack ch1", ext_ack[1], 1);
        check_eq("R7", "own ch ext req ignored", arb_req[2], 0);
        check_eq("R7", "own ch ext ack low", ext_ack[2], 0);
        other_ack = 4'b0010;
        push_emit(16'hC0DE);
        wait_emit(8, 30);
        check_eq("R7", "event on ch2", emit_cnt, 8);
        ext_req = '0; other_ack = '0;
        cycles(2);
        sel_v = 2'd0;

        // R8 end of sequence
        push_word({2'b00, 16'h0000});
        push_emit(16'h4444);
        base = seen_cnt;
        cycles(12);
        check_eq("R8", "done set", done, 1);
        check_eq("R8", "no event after end", seen_cnt, base);
        check_eq("R8", "next word kept", fq.size(), 1);
        en = 1'b0;
        cycles(2);
        check_eq("R8", "done cleared", done, 0);
        en = 1'b1;
        wait_emit(9, 30);
        check_eq("R8", "resume after re-enable", emit_cnt, 9);

        // R9 abort a long delay
        push_word({2'b10, 16'hFFFF});
        push_emit(16'h5555);
        cycles(10);
        en = 1'b0;
        cycles(3);
        en = 1'b1;
        wait_emit(10, 20);
        check_eq("R9", "delay aborted", emit_cnt, 10);

        // R9 handshake completes across disable; R6 no pop while disabled
        ack_lat = 4;
        push_emit(16'h6666);
        base = seen_cnt;
        for (int i = 0; i < 40 && seen_cnt == base; i++) @(negedge clk);
        en = 1'b0;
        wait_emit(11, 30);
        check_eq("R9", "handshake finished", emit_cnt, 11);
        check_eq("R9", "request released", arb_req[0], 0);
        ack_lat = 2;
        push_emit(16'h7777);
        base = seen_cnt;
        cycles(10);
        check_eq("R6", "no pop while disabled", fq.size(), 1);
        check_eq("R6", "no event while disabled", seen_cnt, base);
        en = 1'b1;
        wait_emit(12, 30);
        check_eq("R6", "resumed", emit_cnt, 12);

        // R10 interrupts
        cycles(4);
        ie = n_irq_e; ih = n_irq_h;
        for (int k = 0; k < 6; k++) push_emit(16'h8000 + 16'(k));
        wait_emit(18, 200);
        cycles(4);
        check_eq("R10", "empty pulses", n_irq_e - ie, 1);
        check_eq("R10", "half pulses", n_irq_h - ih, 1);

        check_eq("R2", "label/request held until ack", hold_err, 0);
        check_eq("R6", "pops while empty", bad_pop, 0);
        check_eq("R2", "leftover expected events", exp_q.size(), 0);
        finish_run();
    end
endmodule